// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block sits beside a processor core and counts what the core reports. The core drives a vector of event lines and stall lines, and a bit that tells whether it is running in supervisor mode. The block holds two 32-bit counters. Each counter watches one line, chosen by an 8-bit event code, and has two ways of counting. In occurrence mode it adds one on each rising edge of the line. In duration mode it adds one for every cycle the line is high. Each counter also has its own privilege mask, so counting can be limited to supervisor code, to user code, or allowed in both.

Software uses a small word-addressed register port. A control word holds a master enable, the two sets of per-counter fields, and a chain bit. When the chain bit is set, the second counter ignores its own event and advances only when the first counter wraps. The counters are plain read and write words. Software clears or presets a counter by writing to it. The counters wrap modulo 2^32 and raise no interrupt.

Top module: `perf_monitor_top`

## Requirements
- R1: Synchronous reset clears the control word and both counters to zero, so nothing counts until software writes the control word.
- R2: With its mode bit at 0 (duration), a counter adds one at every clock edge where its selected line is high. The selected line is ev_in indexed by the counter's 8-bit event code.
- R3: With its mode bit at 1 (occurrence), a counter adds one only at an edge where its selected line is high and was low at the previous edge. A line held high counts once.
- R4: Control bit 0 is the master enable. While it is 0, neither counter changes except by a direct write. The per-counter fields keep the values that were last written and read back unchanged.
- R5: Each counter has a privilege field. Its low bit allows counting while priv_sup is 1, and its high bit allows counting while priv_sup is 0. A counter does not advance in a disallowed mode.
- R6: Writing a counter address loads bus_wdata into that counter. If an increment falls in the same cycle, the write wins.
- R7: A counter advances by at most one per cycle and wraps from 0xFFFFFFFF to 0 without any other effect.
- R8: With control bit 23 (chain) set, counter 1 ignores its own event. It advances exactly when counter 0 wraps from 0xFFFFFFFF to 0.
- R9: A control-word write changes only configuration. Both counts keep their values across it, including the count of a counter whose fields were rewritten unchanged.
- R10: Register map: the control word is at 0x0, counter 0 at 0x4 and counter 1 at 0x8. Other addresses read as zero. Counter 0 uses control bits [8:1] (event code), bit 9 (mode) and [11:10] (privilege). Counter 1 uses the same fields shifted up by 11, at [19:12], 20 and [22:21]. Control bits [31:24] read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ev_in | input | 256 | Event and stall lines, indexed by event code |
| priv_sup | input | 1 | 1 while the core runs in supervisor mode, 0 in user mode |

## Verification
The assertions check on every cycle the rules that limit how a counter may move: a frozen count while the master enable is off or the privilege mask blocks the current mode, a load of exactly the written value, a step of at most one, and a chained upper counter that holds still unless the lower one is at all ones. Whether the right line was picked, whether occurrence mode counts edges rather than levels, and whether configuration survives a disable can only be shown by the bench's scenarios. Those scenarios compare read-back counts against values worked out from the requirements.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int CNT_W  = 32;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 8;
    localparam int N_CNT  = 2;
    localparam int ADDR_W = 4;
    localparam int SPAN   = 1 << SEL_W;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_CNT0 = 4'h4;
    localparam logic [ADDR_W-1:0] ADDR_CNT1 = 4'h8;

    // Per-counter field group; the event code sits in the low bits.
    typedef struct packed {
        logic [1:0]       priv;   // [0] supervisor allowed, [1] user allowed
        logic             occ;    // 1 = count rising edges, 0 = count high cycles
        logic [SEL_W-1:0] sel;    // index into the event vector
    } cnt_cfg_t;

    localparam int CFG_W = $bits(cnt_cfg_t);

    // Control word: master enable at bit 0, counter groups above it, chain on top.
    typedef struct packed {
        logic                  chain;
        cnt_cfg_t [N_CNT-1:0]  c;
        logic                  enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        REG_CTRL,
        REG_CNT0,
        REG_CNT1,
        REG_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        case (a)
            ADDR_CTRL: return REG_CTRL;
            ADDR_CNT0: return REG_CNT0;
            ADDR_CNT1: return REG_CNT1;
            default:   return REG_NONE;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] counter_addr(int idx);
        return ADDR_W'(ADDR_CNT0 + 4 * idx);
    endfunction

    function automatic logic priv_allowed(logic [1:0] priv, logic sup);
        return sup ? priv[0] : priv[1];
    endfunction

endpackage

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
    import perfmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl
);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (wr_en)
            ctrl <= ctrl_t'(wdata);
    end

endmodule

// File: rtl/pm_event_tap.sv
module pm_event_tap
    import perfmon_pkg::*;
#(
    parameter int NUM_EVT = SPAN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] ev_in,
    input  cnt_cfg_t           cfg,
    input  logic               glob_en,
    input  logic               priv_sup,
    output logic               hit
);

    logic [SPAN-1:0] ev_pad;
    logic            cur;
    logic            prev_q;
    logic            level;

    always_comb begin
        ev_pad                = '0;
        ev_pad[NUM_EVT-1:0]   = ev_in;
    end

    assign cur = ev_pad[cfg.sel];

    // Remembers the selected line at the previous edge for edge detection.
    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else
            prev_q <= cur;
    end

    assign level = cfg.occ ? (cur & ~prev_q) : cur;
    assign hit   = glob_en & priv_allowed(cfg.priv, priv_sup) & level;

endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (wr_en)
            cnt <= wdata;
        else if (inc)
            cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/perf_monitor_top.sv
module perf_monitor_top
    import perfmon_pkg::*;
#(
    parameter int NUM_EVT = SPAN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_EVT-1:0] ev_in,
    input  logic               priv_sup
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q [N_CNT];
    logic [N_CNT-1:0] hit;
    logic [N_CNT-1:0] inc;
    logic [N_CNT-1:0] wr_cnt;
    logic [N_CNT-1:0] carry;
    logic             wr_ctrl;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);

    pm_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_ctrl),
        .wdata (bus_wdata[CTRL_W-1:0]),
        .ctrl  (ctrl_q)
    );

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        assign wr_cnt[i] = bus_wr && (bus_addr == counter_addr(i));

        pm_event_tap #(.NUM_EVT(NUM_EVT)) u_tap (
            .clk      (clk),
            .rst      (rst),
            .ev_in    (ev_in),
            .cfg      (ctrl_q.c[i]),
            .glob_en  (ctrl_q.enable),
            .priv_sup (priv_sup),
            .hit      (hit[i])
        );

        if (i == 0) begin : g_base
            assign inc[i] = hit[i];
        end else begin : g_link
            assign inc[i] = ctrl_q.chain ? carry[i-1] : hit[i];
        end

        // Wrap of this counter, offered to the next one in chain mode.
        if (i < N_CNT - 1) begin : g_carry
            assign carry[i] = inc[i] & ~wr_cnt[i] & (&cnt_q[i]);
        end else begin : g_top
            assign carry[i] = 1'b0;
        end

        pm_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_cnt[i]),
            .wdata (bus_wdata[CNT_W-1:0]),
            .inc   (inc[i]),
            .cnt   (cnt_q[i])
        );
    end

    always_comb begin
        case (decode_addr(bus_addr))
            REG_CTRL: bus_rdata = DATA_W'(ctrl_q);
            REG_CNT0: bus_rdata = DATA_W'(cnt_q[0]);
            REG_CNT1: bus_rdata = DATA_W'(cnt_q[1]);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pm_checker.sv
module pm_checker
    import perfmon_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              priv_sup,
    input ctrl_t             ctrl,
    input logic [CNT_W-1:0]  cnt0,
    input logic [CNT_W-1:0]  cnt1
);

    logic wr0, wr1;
    assign wr0 = bus_wr && (bus_addr == ADDR_CNT0);
    assign wr1 = bus_wr && (bus_addr == ADDR_CNT1);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cnt0 == '0 && cnt1 == '0 && ctrl == '0)); // R1

    AST_HALT_WHEN_OFF0: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.enable && !wr0) |=> $stable(cnt0)); // R4

    AST_HALT_WHEN_OFF1: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.enable && !wr1) |=> $stable(cnt1)); // R4

    AST_PRIV_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (!wr0 && (priv_sup ? !ctrl.c[0].priv[0] : !ctrl.c[0].priv[1])) |=> $stable(cnt0)); // R5

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        wr0 |=> (cnt0 == $past(bus_wdata))); // R6

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !wr0 |=> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + CNT_W'(1))); // R7

    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctrl.chain && !wr1 && cnt0 != '1) |=> $stable(cnt1)); // R8

endmodule

bind perf_monitor_top pm_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .priv_sup  (priv_sup),
    .ctrl      (ctrl_q),
    .cnt0      (cnt_q[0]),
    .cnt1      (cnt_q[1])
);

// File: tb/test_perf_monitor_top.sv
`timescale 1ns/100ps
module test_perf_monitor_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_wr;
    logic [3:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [255:0] ev_in;
    logic         priv_sup;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    perf_monitor_top i_perf_monitor_top (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ev_in     (ev_in),
        .priv_sup  (priv_sup)
    );

    // Control words: counter 0 duration on code 2, counter 1 occurrence on code 5.
    localparam logic [31:0] CFG_A   = 32'h0070_5C05; // both privilege bits on both counters
    localparam logic [31:0] CFG_B   = 32'h0070_5405; // counter 0 supervisor only
    localparam logic [31:0] CFG_OFF = 32'h0070_5404; // CFG_B with master enable cleared
    localparam logic [31:0] CFG_CH  = 32'h00F0_5C05; // CFG_A with chain set

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] wd;
        logic [7:0]  ev;
        logic        sup;
        logic [31:0] e0;
        logic [31:0] e1;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'h0, CFG_A,   8'h00, 1'b1, 32'd0, 32'd0}, // R2 config load
        '{1'b0, 4'h0, 32'd0,   8'h04, 1'b1, 32'd1, 32'd0}, // R2
        '{1'b0, 4'h0, 32'd0,   8'h04, 1'b1, 32'd2, 32'd0}, // R2
        '{1'b0, 4'h0, 32'd0,   8'h20, 1'b1, 32'd2, 32'd1}, // R3 rise
        '{1'b0, 4'h0, 32'd0,   8'h20, 1'b1, 32'd2, 32'd1}, // R3 held
        '{1'b0, 4'h0, 32'd0,   8'h24, 1'b1, 32'd3, 32'd1}, // R3 held
        '{1'b0, 4'h0, 32'd0,   8'h00, 1'b1, 32'd3, 32'd1}, // R3 fall
        '{1'b0, 4'h0, 32'd0,   8'h20, 1'b1, 32'd3, 32'd2}, // R3 rise again
        '{1'b0, 4'h0, 32'd0,   8'h24, 1'b0, 32'd4, 32'd2}, // R5 user allowed
        '{1'b1, 4'h0, CFG_B,   8'h04, 1'b1, 32'd5, 32'd2}, // R9 ctrl write keeps counts
        '{1'b0, 4'h0, 32'd0,   8'h04, 1'b0, 32'd5, 32'd2}, // R5 user blocked
        '{1'b0, 4'h0, 32'd0,   8'h04, 1'b1, 32'd6, 32'd2}, // R5 supervisor allowed
        '{1'b0, 4'h0, 32'd0,   8'h20, 1'b0, 32'd6, 32'd3}, // R5 counter 1 user ok
        '{1'b1, 4'h0, CFG_OFF, 8'h24, 1'b1, 32'd7, 32'd3}, // R4 last count before off
        '{1'b0, 4'h0, 32'd0,   8'h00, 1'b1, 32'd7, 32'd3}, // R4
        '{1'b0, 4'h0, 32'd0,   8'h24, 1'b1, 32'd7, 32'd3}, // R4 halted
        '{1'b0, 4'h0, 32'd0,   8'h04, 1'b1, 32'd7, 32'd3}  // R4 halted
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drives one cycle of inputs and returns just after the following falling edge.
    task automatic step(input logic wr, input logic [3:0] a, input logic [31:0] d,
                        input logic [7:0] ev, input logic sup);
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = d;
        ev_in     = {248'd0, ev};
        priv_sup  = sup;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        ev_in  = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic expect_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        check(v === exp, tag, v, exp);
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; ev_in = '0; priv_sup = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Events present during reset must not leave a count behind.
        rst = 1'b0;
        expect_reg(4'h0, 32'd0, "R1 ctrl after reset");
        expect_reg(4'h4, 32'd0, "R1 cnt0 after reset");
        expect_reg(4'h8, 32'd0, "R1 cnt1 after reset");
        step(1'b0, 4'h0, 32'd0, 8'hFF, 1'b1);
        expect_reg(4'h4, 32'd0, "R1 no count while ctrl is zero");

        for (int k = 0; k < NV; k++) begin
            logic [31:0] v0, v1;
            step(VEC[k].wr, VEC[k].addr, VEC[k].wd, VEC[k].ev, VEC[k].sup);
            rd(4'h4, v0);
            rd(4'h8, v1);
            check(v0 === VEC[k].e0, $sformatf("R2/R3/R5 vec %0d cnt0", k), v0, VEC[k].e0);
            check(v1 === VEC[k].e1, $sformatf("R3/R9 vec %0d cnt1", k), v1, VEC[k].e1);
        end

        // R4: configuration kept while disabled
        expect_reg(4'h0, CFG_OFF, "R4 config retained");

        // R6: write wins over increment in the same cycle
        step(1'b1, 4'h0, CFG_A, 8'h00, 1'b1);
        step(1'b1, 4'h4, 32'h100, 8'h04, 1'b1);
        expect_reg(4'h4, 32'h100, "R6 write beats increment");
        step(1'b0, 4'h0, 32'd0, 8'h04, 1'b1);
        expect_reg(4'h4, 32'h101, "R6 counting resumes");

        // R7: silent wrap
        step(1'b1, 4'h4, 32'hFFFF_FFFF, 8'h00, 1'b1);
        step(1'b0, 4'h0, 32'd0, 8'h04, 1'b1);
        expect_reg(4'h4, 32'h0, "R7 wrap to zero");
        expect_reg(4'h8, 32'd3, "R7 unchained neighbour unchanged");

        // R8: chaining
        step(1'b1, 4'h0, CFG_CH, 8'h00, 1'b1);
        step(1'b1, 4'h8, 32'd7, 8'h00, 1'b1);
        step(1'b1, 4'h4, 32'hFFFF_FFFE, 8'h00, 1'b1);
        step(1'b0, 4'h0, 32'd0, 8'h24, 1'b1);
        expect_reg(4'h4, 32'hFFFF_FFFF, "R8 lower advanced");
        expect_reg(4'h8, 32'd7, "R8 own event ignored");
        step(1'b0, 4'h0, 32'd0, 8'h24, 1'b1);
        expect_reg(4'h4, 32'h0, "R8 lower wrapped");
        expect_reg(4'h8, 32'd8, "R8 upper took carry");
        step(1'b0, 4'h0, 32'd0, 8'h20, 1'b1);
        expect_reg(4'h8, 32'd8, "R8 upper ignores rise");

        // R10: map and reserved bits
        step(1'b1, 4'h0, 32'hFFFF_FFFF, 8'h00, 1'b1);
        expect_reg(4'h0, 32'h00FF_FFFF, "R10 reserved bits read zero");
        expect_reg(4'hC, 32'h0, "R10 unmapped address");
        step(1'b1, 4'h0, 32'h0, 8'h00, 1'b1);

        // R1 again mid-run
        step(1'b1, 4'h4, 32'h55, 8'h00, 1'b1);
        rst = 1'b1;
        step(1'b0, 4'h0, 32'd0, 8'h00, 1'b1);
        rst = 1'b0;
        expect_reg(4'h4, 32'd0, "R1 cnt0 after second reset");
        expect_reg(4'h8, 32'd0, "R1 cnt1 after second reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule